// File: doc/BRIEF.md
# Error Indicator Latch Controller

This block turns the single-cycle error strobes of an upstream character checker into two indicator outputs: a display line and a relay drive. Both are inactive at rest. When an error is accepted, the display is lit for a configurable operate time. It is followed by a configurable inhibit window, and errors arriving in that window are dropped rather than stored. Each error strobe is qualified on its rising edge, so an input held high counts once.

The relay follows one of three policies, picked by a two-bit mode input. The mode is sampled at the moment the first error is accepted from the idle state.
- Pulse policy (mode 0): the relay follows the display, so it energises once for every accepted error.
- Blink policy (mode 1): the relay latches on the first error. Each later accepted error drops it out for one operate time, after which it picks up again.
- Permanent policy (mode 2, and also code 3): the relay latches on the first error and ignores all further errors.

A synchronous clear returns everything to idle.

The control is a six-state machine:
- `ST_IDLE`: dark, waiting for an error.
- `ST_PULSE`: first operate time, with the display lit.
- `ST_INHIBIT`: dead time after any operate period.
- `ST_HELD`: blink policy, relay latched and waiting for a later error.
- `ST_DROP`: blink policy, relay released while the display is lit.
- `ST_LOCKED`: permanent policy, relay latched and deaf to errors.

The transitions are:
- IDLE→PULSE on an accepted error.
- PULSE/DROP→INHIBIT when the operate count ends and the inhibit length is non-zero. If the inhibit length is zero, they go directly to the policy's rest state.
- INHIBIT→rest state when the inhibit count ends. The rest state is IDLE for pulse, HELD for blink and LOCKED for permanent.
- HELD→DROP on an accepted error.
- Any state→IDLE on clear.

Top module: `err_indicator_ctrl`

## Requirements
- R1: After reset, and whenever the machine is idle, `disp_o` and `relay_o` are both 0.
- R2: An error accepted at clock edge k sets `disp_o` to 1 from edge k through edge k+N-1, where N is `op_ticks_i`. An `op_ticks_i` of 0 acts as N=1.
- R3: With `mode_i`=0 (pulse), `relay_o` is 1 during exactly the same cycles as `disp_o`, and 0 otherwise.
- R4: An error sampled at any of edges k+1 to k+N+M is discarded and has no later effect, where M is `inh_ticks_i`. An error sampled at edge k+N+M+1 is accepted.
- R5: With `mode_i`=1 (blink), `relay_o` rises with the first accepted error and stays 1. Each later accepted error holds `relay_o` at 0 for N cycles while `disp_o` is 1, and then `relay_o` returns to 1.
- R6: With `mode_i`=2 or 3 (permanent), `relay_o` stays 1 after the first accepted error until clear or reset. Later errors light neither output.
- R7: `clr_i` sampled high forces both outputs to 0 and the machine to idle on that edge, and it wins over a simultaneous error. The next error is then handled as a first error.
- R8: An error counts only on a 0→1 transition of `err_i`. A level held high produces a single acceptance.
- R9: The policy is captured when an error is accepted from idle. Changing `mode_i` while latched does not change the behaviour until the machine is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all counts are in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous return to idle |
| err_i | input | 1 | Error strobe from the checker, taken on its rising edge |
| mode_i | input | 2 | Relay policy: 0 pulse, 1 blink, 2 or 3 permanent |
| op_ticks_i | input | CNT_W (16) | Operate time in cycles (0 acts as 1) |
| inh_ticks_i | input | CNT_W (16) | Inhibit length in cycles |
| disp_o | output | 1 | Display indicator, 1 during an operate period |
| relay_o | output | 1 | Relay drive, 1 when energised |

## Verification
The bench places an error on the last edge of the inhibit window and again on the first edge after it. A design whose window is off by one cycle either accepts the first or loses the second. It re-fires the blink policy after switching the mode to pulse: a design that reads the mode live would drop the relay for good instead of picking it up again. The bench also holds `err_i` high across the whole window, so a level-sensitive design retriggers, and sends a clear in the same cycle as an error, so a design that lets the error win re-lights the outputs. It programs a zero operate time, which a naive counter would underflow into a very long pulse.

// File: rtl/eil_pkg.sv
package eil_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_INHIBIT,
        ST_HELD,
        ST_DROP,
        ST_LOCKED
    } eil_state_e;

    typedef enum logic [1:0] {
        POL_PULSE = 2'd0,
        POL_BLINK = 2'd1,
        POL_PERM  = 2'd2
    } eil_policy_e;

    // Mode code to relay policy; code 3 folds onto permanent.
    function automatic eil_policy_e decode_mode(input logic [1:0] code);
        eil_policy_e p;
        unique case (code)
            2'd0:    p = POL_PULSE;
            2'd1:    p = POL_BLINK;
            default: p = POL_PERM;
        endcase
        return p;
    endfunction

    // State entered once the inhibit window of a policy is over.
    function automatic eil_state_e rest_state(input eil_policy_e p);
        eil_state_e s;
        unique case (p)
            POL_PULSE: s = ST_IDLE;
            POL_BLINK: s = ST_HELD;
            POL_PERM:  s = ST_LOCKED;
            default:   s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eil_edge_detect.sv
module eil_edge_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);

    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R8: a held level never yields two consecutive acceptances
    p_single_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/eil_window_timer.sv
module eil_window_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (load_i)       cnt_q <= load_val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last_o = (cnt_q == '0);

    // R2: the window counts down by exactly one per cycle
    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/eil_fsm.sv
module eil_fsm
    import eil_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             err_rise_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] op_ticks_i,
    input  logic [CNT_W-1:0] inh_ticks_i,
    input  logic             tmr_last_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             disp_o,
    output logic             relay_o
);

    eil_state_e  state_q, state_d;
    eil_policy_e pol_q, pol_d;
    logic        disp_q, relay_q;

    logic [CNT_W-1:0] op_load, inh_load;
    logic             inh_zero;

    assign op_load  = (op_ticks_i == '0) ? '0 : op_ticks_i - CNT_W'(1);
    assign inh_zero = (inh_ticks_i == '0);
    assign inh_load = inh_ticks_i - CNT_W'(1);

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        pol_d      = pol_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = op_load;
        unique case (state_q)
            ST_IDLE: begin
                if (err_rise_i) begin
                    state_d    = ST_PULSE;
                    pol_d      = decode_mode(mode_i);
                    tmr_load_o = 1'b1;
                end
            end
            ST_PULSE, ST_DROP: begin
                if (tmr_last_i) begin
                    if (inh_zero) begin
                        state_d = rest_state(pol_q);
                    end else begin
                        state_d    = ST_INHIBIT;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = inh_load;
                    end
                end
            end
            ST_INHIBIT: begin
                if (tmr_last_i) state_d = rest_state(pol_q);
            end
            ST_HELD: begin
                if (err_rise_i) begin
                    state_d    = ST_DROP;
                    tmr_load_o = 1'b1;
                end
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (clr_i) begin
            state_d    = ST_IDLE;
            pol_d      = POL_PULSE;
            tmr_load_o = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pol_q   <= POL_PULSE;
        end else begin
            state_q <= state_d;
            pol_q   <= pol_d;
        end
    end

    // Output register: both outputs follow the entered state on one edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            disp_q  <= 1'b0;
            relay_q <= 1'b0;
        end else begin
            disp_q <= (state_d == ST_PULSE) || (state_d == ST_DROP);
            unique case (state_d)
                ST_PULSE:   relay_q <= 1'b1;
                ST_DROP:    relay_q <= 1'b0;
                ST_INHIBIT: relay_q <= (pol_d != POL_PULSE);
                ST_HELD:    relay_q <= 1'b1;
                ST_LOCKED:  relay_q <= 1'b1;
                default:    relay_q <= 1'b0;
            endcase
        end
    end

    assign disp_o  = disp_q;
    assign relay_o = relay_q;

    // R1: idle is dark
    p_idle_dark_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |-> (!disp_q && !relay_q));

    // R3: first operate period lights both outputs
    p_pulse_lit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PULSE) |-> (disp_q && relay_q));

    // R4: an error inside the inhibit window starts no operate period
    p_inhibit_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_INHIBIT && err_rise_i && !clr_i)
            |=> (state_q != ST_PULSE && state_q != ST_DROP));

    // R5: drop-out releases the relay while the display is lit
    p_drop_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DROP) |-> (disp_q && !relay_q));

    // R6: permanent latch holds until clear
    p_locked_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOCKED && !clr_i) |=> (state_q == ST_LOCKED && relay_q && !disp_q));

    // R7: clear wins and darkens both outputs
    p_clear_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (state_q == ST_IDLE && !disp_q && !relay_q));

endmodule

// File: rtl/err_indicator_ctrl.sv
module err_indicator_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             err_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] op_ticks_i,
    input  logic [CNT_W-1:0] inh_ticks_i,
    output logic             disp_o,
    output logic             relay_o
);

    logic             err_rise;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;

    eil_edge_detect u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (err_i),
        .rise_o (err_rise)
    );

    eil_window_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    eil_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (clr_i),
        .err_rise_i  (err_rise),
        .mode_i      (mode_i),
        .op_ticks_i  (op_ticks_i),
        .inh_ticks_i (inh_ticks_i),
        .tmr_last_i  (tmr_last),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .disp_o      (disp_o),
        .relay_o     (relay_o)
    );

endmodule

// File: tb/err_indicator_ctrl_tb_top.sv
module err_indicator_ctrl_tb_top;

    localparam int CNT_W = 16;
    localparam int N = 3;
    localparam int M = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             err = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [CNT_W-1:0] op_ticks = CNT_W'(N);
    logic [CNT_W-1:0] inh_ticks = CNT_W'(M);
    logic             disp, relay;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    err_indicator_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .clr_i       (clr),
        .err_i       (err),
        .mode_i      (mode),
        .op_ticks_i  (op_ticks),
        .inh_ticks_i (inh_ticks),
        .disp_o      (disp),
        .relay_o     (relay)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raise err for one cycle; starts and ends on a falling edge.
    task automatic fire();
        err = 1'b1;
        @(negedge clk);
        err = 1'b0;
    endtask

    // Count cycles with each output high over len samples.
    task automatic run(input int len, output int dc, output int rc);
        dc = 0;
        rc = 0;
        for (int i = 0; i < len; i++) begin
            dc += int'(disp);
            rc += int'(relay);
            @(negedge clk);
        end
    endtask

    task automatic settle();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 disp after reset", int'(disp), 0);
        check("R1 relay after reset", int'(relay), 0);
    endtask

    task automatic t_pulse_mode();
        int dc, rc;
        mode = 2'd0;
        fire();
        run(12, dc, rc);
        check("R2 display cycles", dc, N);
        check("R3 relay cycles in pulse mode", rc, N);
        check("R1 relay back to idle", int'(relay), 0);
        settle();
    endtask

    task automatic t_op_zero();
        int dc, rc;
        mode = 2'd0;
        op_ticks = '0;
        fire();
        run(8, dc, rc);
        check("R2 zero operate time acts as one", dc, 1);
        check("R3 relay with zero operate time", rc, 1);
        op_ticks = CNT_W'(N);
        settle();
    endtask

    task automatic t_inhibit();
        int dc, rc;
        mode = 2'd0;
        fire();
        repeat (N + M - 1) @(negedge clk);
        fire();
        run(12, dc, rc);
        check("R4 error on last inhibit edge discarded", dc, 0);
        repeat (4) @(negedge clk);
        fire();
        repeat (N + M) @(negedge clk);
        fire();
        run(12, dc, rc);
        check("R4 error after window accepted", dc, N);
        check("R4 relay after window", rc, N);
        settle();
    endtask

    task automatic t_blink();
        int dc, rc;
        mode = 2'd1;
        fire();
        run(12, dc, rc);
        check("R5 first error display", dc, N);
        check("R5 relay latched", rc, 12);
        mode = 2'd0;
        fire();
        run(12, dc, rc);
        check("R5 later error display", dc, N);
        check("R5 relay drop-out length", N, 12 - rc);
        run(4, dc, rc);
        check("R9 policy kept after mode change", rc, 4);
        settle();
        check("R7 clear releases blink latch", int'(relay), 0);
    endtask

    task automatic t_permanent(input logic [1:0] m);
        int dc, rc;
        mode = m;
        fire();
        run(12, dc, rc);
        check("R6 first error display", dc, N);
        check("R6 relay latched", rc, 12);
        fire();
        run(12, dc, rc);
        check("R6 later error ignored display", dc, 0);
        check("R6 later error ignored relay", rc, 12);
        settle();
    endtask

    task automatic t_clear();
        int dc, rc;
        mode = 2'd2;
        fire();
        repeat (10) @(negedge clk);
        clr = 1'b1;
        err = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        err = 1'b0;
        check("R7 clear over error disp", int'(disp), 0);
        check("R7 clear over error relay", int'(relay), 0);
        @(negedge clk);
        mode = 2'd0;
        fire();
        run(12, dc, rc);
        check("R7 first error after clear", dc, N);
        check("R7 pulse policy after clear", rc, N);
        fire();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R7 clear mid-pulse disp", int'(disp), 0);
        check("R7 clear mid-pulse relay", int'(relay), 0);
        settle();
    endtask

    task automatic t_level_hold();
        int dc, rc;
        mode = 2'd0;
        err = 1'b1;
        run(24, dc, rc);
        err = 1'b0;
        check("R8 held level accepted once", dc, N);
        check("R8 relay for held level", rc, N);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulse_mode();
        t_op_zero();
        t_inhibit();
        t_blink();
        t_permanent(2'd2);
        t_permanent(2'd3);
        t_clear();
        t_level_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule